// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a serial memory front end and a memory array model. A write transaction begins with an address load, which fixes the page for the whole transaction and sets a 4-bit offset pointer inside it. Each data byte that the front end accepts is placed in a 16-entry page latch at the current offset. The entry is flagged valid, and the offset then advances.

The offset wraps within the page. If more than 16 bytes arrive, the later bytes replace the earlier ones. Nothing reaches the array until the front end signals STOP.

On STOP, the whole page is handed to the array in one write cycle. The write carries a per-byte mask built from the valid flags. The block then reports busy for a fixed, parameterized programming time. While busy is high, all front-end requests are refused. When programming ends, the valid flags clear.

A STOP that arrives with no buffered bytes starts no programming. This covers a transaction that only set the address.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy_o, arr_we_o and every bit of arr_mask_o are 0.
- R2: A byte accepted on byte_vld_i is stored in the entry selected by the current offset. That entry's bit of arr_mask_o goes to 1, and its data appears on arr_wdata_o bits [8*offset +: 8].
- R3: After each accepted byte, the offset increments modulo 16. arr_page_o stays equal to addr_i[7:4] as captured at the last address load. The first offset is addr_i[3:0].
- R4: When more than 16 bytes are sent, the offset wraps to the start of the page. A later byte replaces the earlier byte in that entry, so the array receives only the last value written to each entry.
- R5: arr_we_o pulses high for exactly one cycle, in the cycle after an accepted STOP. It never goes high while bytes are merely being received.
- R6: busy_o rises in the same cycle as the arr_we_o pulse and stays high for exactly PROG_CYCLES cycles.
- R7: While busy_o is high, addr_load_i, byte_vld_i and stop_i are ignored. The mask stays clear afterwards, and no second write is issued.
- R8: When programming completes (busy_o falls), all bits of arr_mask_o are 0.
- R9: A STOP with no valid entry buffered leaves busy_o and arr_we_o low.
- R10: An address load discards any bytes that have not yet been programmed. It clears all mask bits.
- R11: A single-byte transaction programs exactly one entry and leaves the other addresses of the page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load_i | input | 1 | Strobe: capture addr_i as the start address of a new transaction |
| addr_i | input | ADDR_W | Starting word address |
| byte_vld_i | input | 1 | Strobe: byte_i holds an accepted data byte |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Strobe: STOP seen on the serial bus |
| busy_o | output | 1 | Programming in progress; the front end must refuse requests |
| arr_we_o | output | 1 | One-cycle page write strobe to the array |
| arr_page_o | output | ADDR_W-4 | Page number (upper address bits) of the write |
| arr_mask_o | output | 16 | Per-byte write enables (entry valid flags) |
| arr_wdata_o | output | 16*DATA_W | Page data, entry i at bits [DATA_W*i +: DATA_W] |

## Verification
The assertions assume the front end raises at most one of addr_load_i, byte_vld_i and stop_i per cycle. They also assume it holds reset low for at least one clock from time zero. The directed stimulus drives each strobe for a single cycle on its own. The only exception is the busy-window scenario, which deliberately raises them while busy_o is high, where all of them must be ignored. Every byte transaction begins with an address load, so the offset is always defined.

// File: rtl/pwb_pkg.sv
// Package: shared defaults for the page write buffer.
// Assumes a byte-wide data path and a power-of-two page size.
package pwb_pkg;
    localparam int unsigned PWB_ADDR_W    = 8;
    localparam int unsigned PWB_DATA_W    = 8;
    localparam int unsigned PWB_OFS_W     = 4;
    localparam int unsigned PWB_PROG_CYC  = 20;
endpackage

// File: rtl/pwb_addr_ctr.sv
// Address latch: holds the page number and the in-page offset.
// Assumes load and advance are never asserted in the same cycle by the caller;
// load takes precedence if they are.
module pwb_addr_ctr #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned OFS_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    advance,
    output logic [ADDR_W-OFS_W-1:0] page,
    output logic [OFS_W-1:0]        ofs
);
    // Capture the start address, then step only the low offset bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            ofs  <= '0;
        end else if (load) begin
            page <= addr[ADDR_W-1:OFS_W];
            ofs  <= addr[OFS_W-1:0];
        end else if (advance) begin
            ofs  <= ofs + 1'b1;
        end
    end
endmodule

// File: rtl/pwb_page_latch.sv
// Page latch: one data register and one valid flag per entry.
// Assumes clear and write do not collide; clear wins if they do.
module pwb_page_latch #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFS_W  = 4,
    localparam int unsigned DEPTH = 1 << OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [OFS_W-1:0]        ofs,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH-1:0]        valid,
    output logic [DEPTH*DATA_W-1:0] data
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Store a byte into this entry when the offset selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g]                  <= 1'b0;
                data[g*DATA_W +: DATA_W]  <= '0;
            end else if (clr) begin
                valid[g]                  <= 1'b0;
            end else if (wr && ofs == OFS_W'(g)) begin
                valid[g]                  <= 1'b1;
                data[g*DATA_W +: DATA_W]  <= din;
            end
        end
    end
endmodule

// File: rtl/pwb_prog_timer.sv
// Programming timer: issues the one-cycle array write and holds busy
// for PROG_CYCLES cycles. Assumes go is only raised while not busy.
module pwb_prog_timer #(
    parameter int unsigned PROG_CYCLES = 20,
    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic we,
    output logic done
);
    logic [CNT_W-1:0] remain;

    // Last busy cycle: programming finishes at the coming edge.
    assign done = busy && (remain == '0);

    // Start, count down and end the programming interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            we     <= 1'b0;
            remain <= '0;
        end else if (go && !busy) begin
            busy   <= 1'b1;
            we     <= 1'b1;
            remain <= CNT_W'(PROG_CYCLES - 1);
        end else begin
            we <= 1'b0;
            if (done)      busy   <= 1'b0;
            else if (busy) remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/page_write_buffer.sv
// Top: collects one write transaction into a page latch and commits it to
// the array at STOP. Requests are refused while busy_o is high.
// Assumes at most one of the three strobes is raised per cycle.
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W      = PWB_ADDR_W,
    parameter int unsigned DATA_W      = PWB_DATA_W,
    parameter int unsigned PROG_CYCLES = PWB_PROG_CYC,
    localparam int unsigned OFS_W      = PWB_OFS_W,
    localparam int unsigned DEPTH      = 1 << OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_load_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    byte_vld_i,
    input  logic [DATA_W-1:0]       byte_i,
    input  logic                    stop_i,
    output logic                    busy_o,
    output logic                    arr_we_o,
    output logic [ADDR_W-OFS_W-1:0] arr_page_o,
    output logic [DEPTH-1:0]        arr_mask_o,
    output logic [DEPTH*DATA_W-1:0] arr_wdata_o
);
    logic             load_acc, byte_acc, stop_acc, prog_done;
    logic [OFS_W-1:0] ofs;

    // Gate every front-end request with busy.
    assign load_acc = addr_load_i && !busy_o;
    assign byte_acc = byte_vld_i && !busy_o && !addr_load_i;
    assign stop_acc = stop_i && !busy_o && (|arr_mask_o);

    pwb_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_acc),
        .addr    (addr_i),
        .advance (byte_acc),
        .page    (arr_page_o),
        .ofs     (ofs)
    );

    pwb_page_latch #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (prog_done || load_acc),
        .wr    (byte_acc),
        .ofs   (ofs),
        .din   (byte_i),
        .valid (arr_mask_o),
        .data  (arr_wdata_o)
    );

    pwb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (stop_acc),
        .busy  (busy_o),
        .we    (arr_we_o),
        .done  (prog_done)
    );
endmodule

// File: rtl/pwb_checker.sv
// Checker: temporal properties of the page write buffer, bound to the top.
// Assumes the strobes are one-hot and reset is asserted from time zero.
module pwb_checker #(
    parameter int unsigned PAGE_W      = 4,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned WDATA_W     = 128,
    parameter int unsigned PROG_CYCLES = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               addr_load_i,
    input logic               byte_vld_i,
    input logic               stop_i,
    input logic               busy_o,
    input logic               arr_we_o,
    input logic [PAGE_W-1:0]  arr_page_o,
    input logic [DEPTH-1:0]   arr_mask_o,
    input logic [WDATA_W-1:0] arr_wdata_o
);
    logic [31:0] run_len;

    // Count consecutive busy cycles to check the programming window length.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 1;
        else             run_len <= '0;
    end

    p_single_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |=> !arr_we_o);
    p_we_with_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o && (run_len == 0));
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_len == PROG_CYCLES);
    p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> run_len < PROG_CYCLES);
    p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> arr_mask_o == '0);
    p_nonempty_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> arr_mask_o != '0);
    p_empty_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && arr_mask_o == '0) |=> !busy_o);
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(arr_page_o) && $stable(arr_wdata_o));
    p_load_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load_i && !busy_o) |=> arr_mask_o == '0);
    p_mask_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !addr_load_i && !busy_o) |=> arr_mask_o != '0);
endmodule

bind page_write_buffer pwb_checker #(
    .PAGE_W      (ADDR_W - OFS_W),
    .DEPTH       (DEPTH),
    .WDATA_W     (DEPTH * DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_pwb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_load_i (addr_load_i),
    .byte_vld_i  (byte_vld_i),
    .stop_i      (stop_i),
    .busy_o      (busy_o),
    .arr_we_o    (arr_we_o),
    .arr_page_o  (arr_page_o),
    .arr_mask_o  (arr_mask_o),
    .arr_wdata_o (arr_wdata_o)
);

// File: tb/tb_page_write_buffer.sv
// Directed bench: one task per scenario, with a behavioural array model.
module tb_page_write_buffer;
    localparam int PROG = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         addr_load_i = 1'b0;
    logic [7:0]   addr_i = '0;
    logic         byte_vld_i = 1'b0;
    logic [7:0]   byte_i = '0;
    logic         stop_i = 1'b0;
    logic         busy_o, arr_we_o;
    logic [3:0]   arr_page_o;
    logic [15:0]  arr_mask_o;
    logic [127:0] arr_wdata_o;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    always #2 clk = ~clk;

    page_write_buffer #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
        .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_page_o(arr_page_o),
        .arr_mask_o(arr_mask_o), .arr_wdata_o(arr_wdata_o)
    );

    // Behavioural memory array: applies masked page writes.
    always @(posedge clk) begin
        if (arr_we_o) begin
            writes <= writes + 1;
            for (int i = 0; i < 16; i++)
                if (arr_mask_o[i]) mem[{arr_page_o, 4'(i)}] <= arr_wdata_o[i*8 +: 8];
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic check(input logic ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic load(input logic [7:0] a);
        addr_load_i = 1'b1; addr_i = a; cyc(); addr_load_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        byte_vld_i = 1'b1; byte_i = b; cyc(); byte_vld_i = 1'b0;
    endtask

    // Issue STOP and, if a program is expected, measure the busy window.
    task automatic stop_and_wait(input logic expect_prog, input string req);
        int n;
        stop_i = 1'b1; cyc(); stop_i = 1'b0;
        if (!expect_prog) begin
            check(!busy_o && !arr_we_o, req, {busy_o, arr_we_o}, 0);
            cyc();
            check(!busy_o, req, busy_o, 0);
            return;
        end
        check(arr_we_o && busy_o, "R5", {busy_o, arr_we_o}, 3);
        cyc();
        check(!arr_we_o, "R5", arr_we_o, 0);
        n = 2;
        while (busy_o && n < 1000) begin cyc(); n++; end
        check(n - 1 == PROG, "R6", n - 1, PROG);
        check(arr_mask_o == 0, "R8", arr_mask_o, 0);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int idx = 0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) begin bad++; idx = i; end
        check(bad == 0, req, mem[idx], exp_mem[idx]);
    endtask

    task automatic t_reset();
        check(!busy_o && !arr_we_o && arr_mask_o == 0, "R1", {busy_o, arr_we_o, arr_mask_o}, 0);
    endtask

    task automatic t_single();
        load(8'h37);
        send(8'hA5);
        check(arr_mask_o == 16'h0080, "R2", arr_mask_o, 16'h0080);
        check(arr_wdata_o[7*8 +: 8] == 8'hA5, "R2", arr_wdata_o[7*8 +: 8], 8'hA5);
        check(!arr_we_o && !busy_o, "R5", arr_we_o, 0);
        exp_mem[8'h37] = 8'hA5;
        stop_and_wait(1'b1, "R11");
        cmp_mem("R11");
    endtask

    task automatic t_wrap_page();
        load(8'h9B);
        for (int i = 0; i < 16; i++) begin
            send(8'h10 + 8'(i));
            exp_mem[{4'h9, 4'(4'hB + i)}] = 8'h10 + 8'(i);
        end
        check(arr_page_o == 4'h9, "R3", arr_page_o, 4'h9);
        check(arr_mask_o == 16'hFFFF, "R3", arr_mask_o, 16'hFFFF);
        check(!arr_we_o, "R5", arr_we_o, 0);
        stop_and_wait(1'b1, "R3");
        cmp_mem("R3");
    endtask

    task automatic t_overflow();
        load(8'h50);
        for (int i = 0; i < 18; i++) send(8'hC0 + 8'(i));
        for (int i = 0; i < 16; i++) exp_mem[{4'h5, 4'(i)}] = 8'hC0 + 8'(i);
        exp_mem[8'h50] = 8'hD0;
        exp_mem[8'h51] = 8'hD1;
        check(arr_wdata_o[7:0] == 8'hD0, "R4", arr_wdata_o[7:0], 8'hD0);
        stop_and_wait(1'b1, "R4");
        cmp_mem("R4");
    endtask

    task automatic t_addr_only();
        int w0;
        w0 = writes;
        load(8'h20);
        stop_and_wait(1'b0, "R9");
        check(writes == w0, "R9", writes, w0);
    endtask

    task automatic t_busy_ignore();
        int w0;
        load(8'hE2);
        send(8'h66);
        exp_mem[8'hE2] = 8'h66;
        stop_i = 1'b1; cyc(); stop_i = 1'b0;
        w0 = writes + 1;
        load(8'h40);
        send(8'h77);
        send(8'h78);
        stop_i = 1'b1; cyc(); stop_i = 1'b0;
        check(arr_mask_o == 16'h0004 && arr_page_o == 4'hE, "R7", {arr_page_o, arr_mask_o}, 20'hE0004);
        while (busy_o) cyc();
        check(arr_mask_o == 0, "R7", arr_mask_o, 0);
        cyc(); cyc();
        check(writes == w0 && !busy_o, "R7", writes, w0);
        cmp_mem("R7");
    endtask

    task automatic t_discard();
        load(8'h71);
        send(8'h11);
        send(8'h12);
        load(8'h83);
        check(arr_mask_o == 0, "R10", arr_mask_o, 0);
        send(8'h99);
        exp_mem[8'h83] = 8'h99;
        stop_and_wait(1'b1, "R10");
        cmp_mem("R10");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        cyc(); cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_single();
        t_wrap_page();
        t_overflow();
        t_addr_only();
        t_busy_ignore();
        t_discard();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule